// File: doc/BRIEF.md
# Multi-Target Parallel Configuration Loader

This block sits on the host side of a board where several programmable targets share one byte-wide configuration bus. The data byte, the configuration clock, the write strobe and the busy return line are common to every target. Each target has its own active-low select. The loader takes configuration bytes from an upstream valid/ready stream. Each byte carries a target index and an end-of-image flag. The loader places each byte on the shared bus for the selected target and holds it there until the busy handshake shows that the target has taken it. When an image ends, it releases the bus and moves on to the next target.

The loader generates the configuration clock itself by dividing the system clock by a programmable ratio. Every bus output changes together with a falling edge of that clock, so the bus is stable at every rising edge. After the last target's image has been written, the loader waits for the shared done line before it reports completion, so all targets leave start-up together. If busy stays high for too long, or done never rises, a programmable timeout ends the load with an error.

Top module: `cfgld_top`

## Requirements
- R1: While reset is held, every select in `csN` is high, `writeN` is high, `dataOe`, `cfgClk`, `loadDone`, `loadError` and `inReady` are all low.
- R2: `cfgClk` has a period of 2·`divRatio` system clocks (a ratio of 0 acts as 1). `csN`, `writeN` and `cfgData` change only in the system cycle in which `cfgClk` falls. The one exception is the entry into the error state.
- R3: A byte is accepted at a rising edge of `cfgClk` only when its target's select is low, `writeN` is low and `busy` is low. While busy is high, the same byte stays on the bus. `inReady` is high for exactly one system cycle per accepted byte, so every stream byte reaches its target once, in order.
- R4: At most one bit of `csN` is low at any time, and `dataOe` is high only while `writeN` is low.
- R5: While any select is low in two consecutive system cycles, `writeN` keeps its level.
- R6: Images are loaded to targets 0, 1, …, NUM_TGT-1 in turn. The `inTarget` of an image's first byte must equal the next target index, or the load ends in error with no byte accepted. The `inTarget` of later bytes in the same image is ignored.
- R7: After the byte flagged `inLast` is accepted, the select and `writeN` both go high at the next fall of `cfgClk`. At least one rising edge with all selects high and `writeN` high comes before a different target is selected.
- R8: If the stream pauses mid-image, the select goes high while `writeN` stays low. Loading resumes on the same target without losing any byte.
- R9: `loadDone` rises only after all images are loaded and `done` is seen high at a rising edge of `cfgClk`. It then stays high.
- R10: If a byte waits with busy high on `timeoutLimit` consecutive rising edges, `loadError` goes high. The bus is released (all selects high, `writeN` high, `dataOe` low) and the error holds until reset. With one edge fewer, the load completes normally.
- R11: If `done` is still low after `timeoutLimit` rising edges in the done-wait phase, `loadError` goes high.
- R12: `loadDone` and `loadError` are never high together, and `inReady` stays low while `loadError` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divRatio | input | DIV_W | Half period of `cfgClk` in system clocks |
| timeoutLimit | input | TO_W | Stall limit in `cfgClk` rising edges |
| inValid | input | 1 | Upstream byte valid |
| inData | input | DATA_W | Upstream configuration byte |
| inTarget | input | TGT_W | Target index tag of the byte |
| inLast | input | 1 | Byte is the last of its image |
| inReady | output | 1 | Byte accepted by the target in this cycle |
| cfgClk | output | 1 | Shared configuration clock |
| cfgData | output | DATA_W | Shared configuration data bus |
| dataOe | output | 1 | Enable for the data bus driver |
| writeN | output | 1 | Shared active-low write strobe |
| csN | output | NUM_TGT | Per-target active-low selects |
| busy | input | 1 | Shared busy from the targets |
| done | input | 1 | Shared done from the targets |
| loadDone | output | 1 | All targets loaded and started |
| loadError | output | 1 | Timeout or target order error |

## Verification
The assertions check the bus rules on every cycle: a single active select, the driver enable only while writing, a steady write level under an active select, bus changes only at falling edges, one-cycle ready only on a free rising edge, and error stickiness and exclusivity. Only the bench scenarios can show the end-to-end results: each target receiving exactly its image across a sweep of divide ratios and busy patterns, the gap between targets, the pause inside an image, the exact timeout boundary, the wrong-order error, and completion held back until done.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAITDONE,
    ST_DONE,
    ST_ERR
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;    // put a new byte on the bus, select target, write low
    logic dropCs;      // deselect during a stream pause, keep write low
    logic releaseBus;  // all selects high, write high, driver off
    logic toCount;     // a stalled rising edge
    logic toClear;     // a rising edge that is not stalled
  } busCmd_t;

endpackage

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = 2,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int TO_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   divRatio,
  input  logic [TO_W-1:0]    timeoutLimit,
  input  busCmd_t            cmd,
  input  logic [TGT_W-1:0]   tgtSel,
  input  logic [DATA_W-1:0]  byteIn,
  output logic               riseTick,
  output logic               fallTick,
  output logic               timeoutHit,
  output logic               cfgClk,
  output logic [DATA_W-1:0]  cfgData,
  output logic               dataOe,
  output logic               writeN,
  output logic [NUM_TGT-1:0] csN
);

  localparam logic [NUM_TGT-1:0] ALL_OFF = {NUM_TGT{1'b1}};

  // clock divider
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLast;
  logic             clkQ;
  logic             edgeNow;

  assign halfLast = (divRatio == '0) ? '0 : divRatio - 1'b1;
  assign edgeNow  = (divCnt >= halfLast);
  assign riseTick = edgeNow && !clkQ;
  assign fallTick = edgeNow && clkQ;
  assign cfgClk   = clkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      clkQ   <= 1'b0;
    end else if (edgeNow) begin
      divCnt <= '0;
      clkQ   <= ~clkQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // stall timeout counter
  logic [TO_W:0] toCnt;
  logic [TO_W:0] toNext;

  assign toNext     = toCnt + 1'b1;
  assign timeoutHit = cmd.toCount && (toNext >= {1'b0, timeoutLimit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            toCnt <= '0;
    else if (cmd.toClear) toCnt <= '0;
    else if (cmd.toCount) toCnt <= toNext;
  end

  // bus registers
  logic [DATA_W-1:0]  dataQ;
  logic               oeQ;
  logic               writeNQ;
  logic [NUM_TGT-1:0] csNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      oeQ     <= 1'b0;
      writeNQ <= 1'b1;
      csNQ    <= ALL_OFF;
    end else if (cmd.releaseBus) begin
      oeQ     <= 1'b0;
      writeNQ <= 1'b1;
      csNQ    <= ALL_OFF;
    end else if (cmd.loadByte) begin
      dataQ   <= byteIn;
      oeQ     <= 1'b1;
      writeNQ <= 1'b0;
      csNQ    <= ~(NUM_TGT'(1) << tgtSel);
    end else if (cmd.dropCs) begin
      oeQ     <= 1'b0;
      csNQ    <= ALL_OFF;
    end
  end

  assign cfgData = dataQ;
  assign dataOe  = oeQ;
  assign writeN  = writeNQ;
  assign csN     = csNQ;

  logic csAny;
  assign csAny = (csNQ != ALL_OFF);

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csNQ) <= 1);

  p_oe_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> !writeNQ);

  p_write_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csAny && $past(csAny)) |-> $stable(writeNQ));

  p_bus_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!fallTick && !cmd.releaseBus) |=> ($stable(csNQ) && $stable(writeNQ) && $stable(dataQ)));

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             riseTick,
  input  logic             fallTick,
  input  logic             timeoutHit,
  input  logic             inValid,
  input  logic [TGT_W-1:0] inTarget,
  input  logic             inLast,
  input  logic             busy,
  input  logic             done,
  output busCmd_t          cmd,
  output logic [TGT_W-1:0] tgtSel,
  output logic             inReady,
  output logic             loadDone,
  output logic             loadError
);

  localparam logic [TGT_W-1:0] LAST_TGT = TGT_W'(NUM_TGT - 1);

  ldState_t         state;
  logic             pending;   // a byte on the bus not yet taken
  logic             lastQ;     // the taken byte closed its image
  logic [TGT_W-1:0] tgtIdx;
  logic             acceptNow;
  logic             stallNow;

  assign acceptNow = riseTick && (state == ST_LOAD) && pending && !busy;
  assign stallNow  = ((state == ST_LOAD) && pending && busy) ||
                     ((state == ST_WAITDONE) && !done);

  always_comb begin
    cmd         = '0;
    cmd.toCount = riseTick && stallNow;
    cmd.toClear = riseTick && !stallNow;
    case (state)
      ST_IDLE: begin
        if (fallTick && inValid) begin
          if (inTarget == tgtIdx) cmd.loadByte   = 1'b1;
          else                    cmd.releaseBus = 1'b1;
        end
      end
      ST_LOAD: begin
        if (timeoutHit) cmd.releaseBus = 1'b1;
        else if (fallTick && !pending) begin
          if (lastQ)        cmd.releaseBus = 1'b1;
          else if (inValid) cmd.loadByte   = 1'b1;
          else              cmd.dropCs     = 1'b1;
        end
      end
      ST_WAITDONE: begin
        if (timeoutHit) cmd.releaseBus = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      lastQ   <= 1'b0;
      tgtIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fallTick && inValid) begin
            if (inTarget == tgtIdx) begin
              state   <= ST_LOAD;
              pending <= 1'b1;
            end else begin
              state <= ST_ERR;
            end
          end
        end
        ST_LOAD: begin
          if (acceptNow) begin
            pending <= 1'b0;
            lastQ   <= inLast;
          end else if (timeoutHit) begin
            state <= ST_ERR;
          end else if (fallTick && !pending) begin
            if (lastQ) begin
              lastQ <= 1'b0;
              if (tgtIdx == LAST_TGT) state <= ST_WAITDONE;
              else begin
                tgtIdx <= tgtIdx + 1'b1;
                state  <= ST_IDLE;
              end
            end else if (inValid) begin
              pending <= 1'b1;
            end
          end
        end
        ST_WAITDONE: begin
          if (riseTick && done) state <= ST_DONE;
          else if (timeoutHit)  state <= ST_ERR;
        end
        default: ;
      endcase
    end
  end

  assign tgtSel    = tgtIdx;
  assign inReady   = acceptNow;
  assign loadDone  = (state == ST_DONE);
  assign loadError = (state == ST_ERR);

  p_ready_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (riseTick && !busy));

  p_done_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadDone) |-> ($past(done) && $past(riseTick)));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    loadError |=> loadError);

  p_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadError));

  p_no_ready_err_r12: assert property (@(posedge clk) disable iff (!rstN)
    loadError |-> !inReady);

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
  import cfgld_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int TO_W    = 16,
  localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   divRatio,
  input  logic [TO_W-1:0]    timeoutLimit,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [TGT_W-1:0]   inTarget,
  input  logic               inLast,
  output logic               inReady,
  output logic               cfgClk,
  output logic [DATA_W-1:0]  cfgData,
  output logic               dataOe,
  output logic               writeN,
  output logic [NUM_TGT-1:0] csN,
  input  logic               busy,
  input  logic               done,
  output logic               loadDone,
  output logic               loadError
);

  busCmd_t          cmd;
  logic [TGT_W-1:0] tgtSel;
  logic             riseTick;
  logic             fallTick;
  logic             timeoutHit;

  cfgld_ctrl #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .riseTick(riseTick), .fallTick(fallTick),
    .timeoutHit(timeoutHit), .inValid(inValid), .inTarget(inTarget),
    .inLast(inLast), .busy(busy), .done(done), .cmd(cmd), .tgtSel(tgtSel),
    .inReady(inReady), .loadDone(loadDone), .loadError(loadError)
  );

  cfgld_dp #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W), .DATA_W(DATA_W),
             .DIV_W(DIV_W), .TO_W(TO_W)) uDp (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .timeoutLimit(timeoutLimit),
    .cmd(cmd), .tgtSel(tgtSel), .byteIn(inData), .riseTick(riseTick),
    .fallTick(fallTick), .timeoutHit(timeoutHit), .cfgClk(cfgClk),
    .cfgData(cfgData), .dataOe(dataOe), .writeN(writeN), .csN(csN)
  );

endmodule

// File: tb/tb_cfgld_top.sv
module tb_cfgld_top;

  localparam int NT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] divRatio = 4'd1;
  logic [7:0] timeoutLimit = 8'd100;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic [1:0] inTarget = '0;
  logic       inLast = 1'b0;
  logic       inReady, cfgClk, dataOe, writeN, loadDone, loadError;
  logic [7:0] cfgData;
  logic [NT-1:0] csN;
  logic       busy = 1'b0;
  logic       done = 1'b0;

  cfgld_top #(.NUM_TGT(NT), .DATA_W(8), .DIV_W(4), .TO_W(8)) dut (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .timeoutLimit(timeoutLimit),
    .inValid(inValid), .inData(inData), .inTarget(inTarget), .inLast(inLast),
    .inReady(inReady), .cfgClk(cfgClk), .cfgData(cfgData), .dataOe(dataOe),
    .writeN(writeN), .csN(csN), .busy(busy), .done(done),
    .loadDone(loadDone), .loadError(loadError)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target model and monitors
  logic [7:0] tgtLog [0:NT-1][0:31];
  int tgtCnt [0:NT-1];
  int sysCyc = 0, lastRise = -1;
  int vR2 = 0, vR3 = 0, vR4 = 0, vR5 = 0, vR7 = 0, vR12 = 0;
  int hsCnt = 0, lastTgt = -1;
  bit gapSeen = 0;
  logic [NT-1:0] pCsN = '1;
  logic pWriteN = 1'b1, pCfgClk = 1'b0;
  logic [7:0] pData = '0;

  always @(posedge clk) sysCyc++;

  always @(posedge cfgClk) if (rstN) begin
    if (lastRise >= 0 && (sysCyc - lastRise) != 2 * int'(divRatio)) vR2++;
    lastRise = sysCyc;
    if (csN == '1 && writeN) gapSeen = 1;
    for (int t = 0; t < NT; t++)
      if (!csN[t] && !writeN && !busy) begin
        if (!dataOe) vR3++;
        if (tgtCnt[t] < 32) tgtLog[t][tgtCnt[t]] = cfgData;
        tgtCnt[t]++;
      end
  end

  always @(negedge clk) if (rstN) begin
    if ((csN != pCsN || writeN != pWriteN || cfgData != pData) &&
        !(pCfgClk && !cfgClk) && !loadError) vR2++;
    if ($countones(~csN) > 1) vR4++;
    if (dataOe && writeN) vR4++;
    if (pCsN != '1 && csN != '1 && writeN != pWriteN) vR5++;
    if (loadError && inReady) vR12++;
    if (inReady && inValid) hsCnt++;
    for (int t = 0; t < NT; t++)
      if (!csN[t] && pCsN[t] && t != lastTgt) begin
        if (!gapSeen) vR7++;
        gapSeen = 0;
        lastTgt = t;
      end
    pCsN = csN; pWriteN = writeN; pData = cfgData; pCfgClk = cfgClk;
  end

  // busy generator: 0 never, 1 alternate, 2 every third, 3 one stall of stallLen edges
  int busyMode = 0, stallLen = 0, stallLeft = 0, riseIdx = 0;
  bit stallUsed = 0;
  always @(negedge cfgClk) begin
    #1;
    riseIdx++;
    case (busyMode)
      1: busy = riseIdx[0];
      2: busy = (riseIdx % 3 == 0);
      3: begin
        if (stallLeft > 0) begin busy = 1'b1; stallLeft--; end
        else busy = 1'b0;
        if (!stallUsed && csN != '1 && stallLen > 0) begin
          stallUsed = 1; stallLeft = stallLen - 1; busy = 1'b1;
        end
      end
      default: busy = 1'b0;
    endcase
  end

  function automatic logic [7:0] pat(int t, int i, int run);
    return 8'((t * 37 + i * 11 + run * 5 + 3) & 255);
  endfunction

  task automatic doReset(int div, int lim, int mode, int stall);
    rstN = 1'b0;
    inValid = 0; inLast = 0; done = 0;
    divRatio = 4'(div); timeoutLimit = 8'(lim);
    busyMode = mode; stallLen = stall; stallUsed = 0; stallLeft = 0;
    busy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < NT; t++) tgtCnt[t] = 0;
    vR2 = 0; vR3 = 0; vR4 = 0; vR5 = 0; vR7 = 0; vR12 = 0;
    hsCnt = 0; lastTgt = -1; gapSeen = 0; lastRise = -1;
    pCsN = '1; pWriteN = 1; pData = '0; pCfgClk = 0;
    @(posedge clk); #1 rstN = 1'b1;
  endtask

  task automatic sendByte(int tgt, logic [7:0] d, bit last);
    inValid = 1; inData = d; inTarget = 2'(tgt); inLast = last;
    do @(negedge clk); while (!inReady && !loadError);
    @(posedge clk); #1;
    inValid = 0;
  endtask

  task automatic checkClean(string tag);
    chk(vR2 == 0, "R2", {tag, " clock period / bus change off falling edge"}, vR2, 0);
    chk(vR3 == 0, "R3", {tag, " byte taken with driver off"}, vR3, 0);
    chk(vR4 == 0, "R4", {tag, " select / driver rule"}, vR4, 0);
    chk(vR5 == 0, "R5", {tag, " write changed under select"}, vR5, 0);
    chk(vR7 == 0, "R7", {tag, " no gap before next target"}, vR7, 0);
    chk(vR12 == 0, "R12", {tag, " ready during error"}, vR12, 0);
  endtask

  // full load of NT images; returns after done handling
  task automatic runLoad(int run, int div, int mode, int stall, int lim, bit pause, bit earlyDone);
    int lens [0:NT-1];
    int total = 0;
    doReset(div, lim, mode, stall);
    if (earlyDone) done = 1;
    for (int t = 0; t < NT; t++) begin
      lens[t] = 1 + t * 2 + (run % 3);
      total += lens[t];
    end
    for (int t = 0; t < NT; t++)
      for (int i = 0; i < lens[t]; i++) begin
        // R6: tag of non-first bytes is ignored, so drive another value
        sendByte((i == 0) ? t : (t + 1) % NT, pat(t, i, run), i == lens[t] - 1);
        if (pause && i == 1) repeat (9 * div + 5) @(posedge clk);
      end
    repeat (12 * div) @(posedge clk);
    @(negedge clk);
    if (!earlyDone) begin
      chk(!loadDone, "R9", $sformatf("run %0d done held back", run), loadDone, 0);
      done = 1;
    end
    repeat (8 * div + 4) @(posedge clk);
    @(negedge clk);
    chk(loadDone, "R9", $sformatf("run %0d loadDone", run), loadDone, 1);
    chk(!loadError, "R12", $sformatf("run %0d no error", run), loadError, 0);
    chk(hsCnt == total, "R3", $sformatf("run %0d ready handshakes", run), hsCnt, total);
    for (int t = 0; t < NT; t++) begin
      int bad = 0;
      for (int i = 0; i < lens[t] && i < 32; i++)
        if (tgtLog[t][i] != pat(t, i, run)) bad++;
      chk(tgtCnt[t] == lens[t], pause ? "R8" : "R6",
          $sformatf("run %0d target %0d byte count", run, t), tgtCnt[t], lens[t]);
      chk(bad == 0, "R3", $sformatf("run %0d target %0d byte mismatches", run, t), bad, 0);
    end
    checkClean($sformatf("run %0d", run));
  endtask

  initial begin
    int run = 0;
    // R1 reset state
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(csN == '1, "R1", "selects in reset", int'(csN), 7);
    chk(writeN == 1 && dataOe == 0 && cfgClk == 0, "R1", "write/oe/clk in reset",
        int'({writeN, dataOe, cfgClk}), 4);
    chk(!loadDone && !loadError && !inReady, "R1", "status in reset",
        int'({loadDone, loadError, inReady}), 0);

    // sweep divide ratio and busy pattern (R2 R3 R4 R5 R7 R9)
    for (int d = 1; d <= 3; d++)
      for (int m = 0; m <= 2; m++) begin
        runLoad(run, d, m, 0, 100, 0, 0);
        run++;
      end

    // R8 pause inside an image
    runLoad(run, 2, 1, 0, 100, 1, 0); run++;

    // R10 stall one edge below limit completes
    runLoad(run, 2, 3, 5, 6, 0, 1); run++;

    // R10 stall at limit -> error and bus released
    doReset(2, 6, 3, 6);
    sendByte(0, 8'h5A, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(loadError, "R10", "busy stall at limit flags error", loadError, 1);
    chk(csN == '1 && writeN && !dataOe, "R10", "bus released after error",
        int'({csN, writeN, dataOe}), 'b11110);
    chk(tgtCnt[0] == 0, "R10", "no byte taken during stall", tgtCnt[0], 0);
    inValid = 1; inData = 8'h11; inTarget = 0; inLast = 0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    inValid = 0;
    chk(vR12 == 0 && !loadDone, "R12", "no ready and no done after error", vR12, 0);
    chk(loadError, "R10", "error sticky", loadError, 1);

    // R11 done never rises
    doReset(1, 10, 0, 0);
    for (int t = 0; t < NT; t++) sendByte(t, pat(t, 0, 50), 1);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(loadError && !loadDone, "R11", "done timeout flags error",
        int'({loadError, loadDone}), 2);

    // R6 wrong first tag -> error, nothing accepted
    doReset(1, 100, 0, 0);
    sendByte(2, 8'hC3, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(loadError, "R6", "wrong target order flags error", loadError, 1);
    chk(tgtCnt[0] + tgtCnt[1] + tgtCnt[2] == 0 && hsCnt == 0, "R6",
        "no byte accepted on wrong tag", tgtCnt[0] + tgtCnt[1] + tgtCnt[2] + hsCnt, 0);
    checkClean("error runs");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R3", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule